// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It handles a small register-to-register and load/store instruction set: the R-format operations add, subtract, and, or and set-less-than, add-immediate, word load, word store, branch-if-equal and an unconditional jump. On each rising edge it commits the result of the instruction that sits at the program counter. In that cycle it decodes the opcode into a set of control bits and reads two general registers. The ALU then combines them. If the instruction is a load or a store it accesses data memory, and then it writes back. The next program counter is the sequential address unless a branch or a jump replaces it.

The instruction store and the data store are word arrays inside the core. A loading port fills them, normally while reset is held. A combinational debug port reads any general register, so a program's effect can be seen from outside the core. The register file keeps its contents through reset and only the program counter is cleared. Register and memory writes from the core are held off while reset is asserted.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter (`pc_o`) becomes 0 on that edge and stays 0 for as long as reset is held.
- R2: An instruction that is neither a branch nor a jump advances `pc_o` by 4. The program counter is always a multiple of 4, and instruction word index `pc_o[IA_W+1:2]` is fetched.
- R3: R-format instructions (opcode 0, shamt 0) write rd with the result of rs op rt. The funct codes are add 0x20, sub 0x22, and 0x24, or 0x25 and slt 0x2A, where slt compares the operands as signed values and returns 1 or 0.
- R4: addi (opcode 0x08) writes rt with rs plus the sign-extended 16-bit immediate.
- R5: lw (opcode 0x23) reads the data word at index (rs + sign-extended imm) >> 2 and writes it to rt.
- R6: sw (opcode 0x2B) writes the rt value to the data word at index (rs + sign-extended imm) >> 2 and writes no register.
- R7: beq (opcode 0x04) sets the program counter to PC+4 + (sign-extended imm << 2) when rs equals rt, and to PC+4 when they differ.
- R8: j (opcode 0x02) sets the program counter to the top 4 bits of PC+4 concatenated with the 26-bit index field shifted left by 2.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: `dbg_data` shows the current contents of register `dbg_addr` combinationally.
- R11: When `ld_en` is high at a rising edge, `ld_data` is written at word index `ld_addr`. It goes to the instruction store when `ld_sel` is 0 and to the data store when `ld_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Memory loading write strobe |
| ld_sel | input | 1 | Loading target: 0 instruction store, 1 data store |
| ld_addr | input | LD_AW | Word index for loading |
| ld_data | input | 32 | Word to load |
| dbg_addr | input | 5 | Debug register select |
| dbg_data | output | 32 | Debug register contents |
| pc_o | output | 32 | Current program counter |

## Verification
The test program is built so that each arithmetic function is applied to one positive and one negative operand. This separates sign handling in slt, and it shows that the immediate is sign-extended rather than zero-extended. A store followed by a load of the same address shows that the two memory paths and the rt destination select work together. A second load uses a negative base register with a positive offset, which exercises the address adder. Branches are tried both taken and not taken. Each branch and each jump skips an instruction that would overwrite a register that is checked later, so a wrong target shows up both in the program counter trace and in the register contents. A write to register 0 checks that such writes are discarded.

// File: rtl/sc_cpu_pkg.sv
package sc_cpu_pkg;
   localparam logic [5:0] OP_RFMT = 6'h00;
   localparam logic [5:0] OP_ADDI = 6'h08;
   localparam logic [5:0] OP_LW   = 6'h23;
   localparam logic [5:0] OP_SW   = 6'h2B;
   localparam logic [5:0] OP_BEQ  = 6'h04;
   localparam logic [5:0] OP_J    = 6'h02;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
   } alu_op_e;

   typedef struct packed {
      logic    reg_we;   // register write enable
      logic    dst_rd;   // 1: destination rd, 0: destination rt
      logic    wb_mem;   // 1: write data from memory, 0: from ALU
      logic    b_imm;    // 1: second operand is the immediate
      logic    mem_we;   // data store write
      logic    branch;   // conditional on equality
      logic    jump;     // unconditional
      alu_op_e alu_op;
   } ctl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
   import sc_cpu_pkg::*;
(
   input  logic [31:0] instr,
   output ctl_t        ctl
);
   logic [5:0] op;
   logic [5:0] fn;
   logic       shamt_zero;

   assign op         = instr[31:26];
   assign fn         = instr[5:0];
   assign shamt_zero = (instr[10:6] == 5'd0);

   always_comb begin
      ctl        = '0;
      ctl.alu_op = ALU_ADD;
      unique case (op)
         OP_RFMT: begin
            ctl.dst_rd = 1'b1;
            if (shamt_zero) begin
               unique case (fn)
                  FN_ADD: begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_ADD; end
                  FN_SUB: begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_SUB; end
                  FN_AND: begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_AND; end
                  FN_OR:  begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_OR;  end
                  FN_SLT: begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_SLT; end
                  default: ;
               endcase
            end
         end
         OP_ADDI: begin ctl.reg_we = 1'b1; ctl.b_imm = 1'b1; end
         OP_LW:   begin ctl.reg_we = 1'b1; ctl.b_imm = 1'b1; ctl.wb_mem = 1'b1; end
         OP_SW:   begin ctl.mem_we = 1'b1; ctl.b_imm = 1'b1; end
         OP_BEQ:  begin ctl.branch = 1'b1; ctl.alu_op = ALU_SUB; end
         OP_J:    ctl.jump = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_cpu_pkg::*;
#(
   parameter int W = 32
) (
   input  alu_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y,
   output logic         zero
);
   if (W < 2) begin : g_bad_w
      $error("sc_alu: W must be at least 2");
   end

   always_comb begin
      unique case (op)
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int W   = 32,
   parameter int AW  = 5,
   parameter int NRP = 3
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [AW-1:0]           waddr,
   input  logic [W-1:0]            wdata,
   input  logic [NRP-1:0][AW-1:0]  raddr,
   output logic [NRP-1:0][W-1:0]   rdata
);
   localparam int NREG = 1 << AW;

   if (AW < 1 || AW > 5) begin : g_bad_aw
      $error("sc_regfile: AW must be in 1..5");
   end

   logic [W-1:0] regs [NREG];

   always_ff @(posedge clk) begin
      if (we && waddr != '0) regs[waddr] <= wdata;
   end

   for (genvar p = 0; p < NRP; p++) begin : g_rport
      assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
   end
endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_cpu_pkg::*;
#(
   parameter int IMEM_WORDS = 64,
   parameter int DMEM_WORDS = 64,
   parameter int LD_AW      = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_en,
   input  logic             ld_sel,
   input  logic [LD_AW-1:0] ld_addr,
   input  logic [31:0]      ld_data,
   input  logic [4:0]       dbg_addr,
   output logic [31:0]      dbg_data,
   output logic [31:0]      pc_o
);
   localparam int W    = 32;
   localparam int RAW  = 5;
   localparam int IA_W = $clog2(IMEM_WORDS);
   localparam int DA_W = $clog2(DMEM_WORDS);

   if (IMEM_WORDS < 2 || (1 << IA_W) != IMEM_WORDS) begin : g_bad_im
      $error("sc_core: IMEM_WORDS must be a power of two >= 2");
   end
   if (DMEM_WORDS < 2 || (1 << DA_W) != DMEM_WORDS) begin : g_bad_dm
      $error("sc_core: DMEM_WORDS must be a power of two >= 2");
   end
   if (LD_AW != IA_W && LD_AW != DA_W) begin : g_bad_ld
      $error("sc_core: LD_AW must match a store index width");
   end
   if (IA_W + 2 > 28) begin : g_bad_span
      $error("sc_core: instruction store too large for jump region");
   end

   logic [W-1:0]     pc_q, pc_nxt, pc_seq, br_tgt, j_tgt;
   logic [W-1:0]     instr, imm_sx, op_b, alu_y, rd_mem, wb_data;
   logic [RAW-1:0]   rs, rt, rd, wr_addr;
   logic             alu_zero, br_taken, rf_we, dmem_we;
   logic [2:0][RAW-1:0] rf_ra;
   logic [2:0][W-1:0]   rf_rd;
   ctl_t             ctl;

   logic [W-1:0] imem [IMEM_WORDS];
   logic [W-1:0] dmem [DMEM_WORDS];

   // instruction fetch
   assign instr = imem[pc_q[IA_W+1:2]];
   assign rs    = instr[25:21];
   assign rt    = instr[20:16];
   assign rd    = instr[15:11];
   assign imm_sx = {{16{instr[15]}}, instr[15:0]};

   sc_decode u_dec (.instr(instr), .ctl(ctl));

   assign rf_ra = {dbg_addr, rt, rs};
   assign dbg_data = rf_rd[2];

   sc_regfile #(.W(W), .AW(RAW), .NRP(3)) u_rf (
      .clk   (clk),
      .we    (rf_we),
      .waddr (wr_addr),
      .wdata (wb_data),
      .raddr (rf_ra),
      .rdata (rf_rd)
   );

   assign op_b = ctl.b_imm ? imm_sx : rf_rd[1];

   sc_alu #(.W(W)) u_alu (
      .op   (ctl.alu_op),
      .a    (rf_rd[0]),
      .b    (op_b),
      .y    (alu_y),
      .zero (alu_zero)
   );

   // data memory
   assign rd_mem  = dmem[alu_y[DA_W+1:2]];
   assign dmem_we = ctl.mem_we && !rst;

   always_ff @(posedge clk) begin
      if (dmem_we) dmem[alu_y[DA_W+1:2]] <= rf_rd[1];
      if (ld_en && ld_sel) dmem[ld_addr[DA_W-1:0]] <= ld_data;
      if (ld_en && !ld_sel) imem[ld_addr[IA_W-1:0]] <= ld_data;
   end

   // writeback
   assign wr_addr = ctl.dst_rd ? rd : rt;
   assign wb_data = ctl.wb_mem ? rd_mem : alu_y;
   assign rf_we   = ctl.reg_we && !rst;

   // next program counter
   assign pc_seq   = pc_q + 32'd4;
   assign br_tgt   = pc_seq + {imm_sx[29:0], 2'b00};
   assign j_tgt    = {pc_seq[31:28], instr[25:0], 2'b00};
   assign br_taken = ctl.branch && alu_zero;

   always_comb begin
      if (ctl.jump)      pc_nxt = j_tgt;
      else if (br_taken) pc_nxt = br_tgt;
      else               pc_nxt = pc_seq;
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_nxt;
   end

   assign pc_o = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
   input logic        clk,
   input logic        rst,
   input logic [31:0] pc,
   input logic        is_branch,
   input logic        is_jump,
   input logic        alu_zero,
   input logic        rf_we,
   input logic        dmem_we,
   input logic        wb_mem,
   input logic [4:0]  wr_addr,
   input logic [4:0]  rt,
   input logic [4:0]  dbg_addr,
   input logic [31:0] dbg_data
);
   assert_pc_reset_R1: assert property (@(posedge clk) rst |=> pc == 32'd0);

   assert_pc_seq_R2: assert property (@(posedge clk) disable iff (rst)
      (!is_branch && !is_jump) |=> pc == $past(pc) + 32'd4);

   assert_pc_align_R2: assert property (@(posedge clk) disable iff (rst)
      pc[1:0] == 2'b00);

   assert_load_rt_R5: assert property (@(posedge clk) disable iff (rst)
      (wb_mem && rf_we) |-> wr_addr == rt);

   assert_store_noreg_R6: assert property (@(posedge clk) disable iff (rst)
      dmem_we |-> !rf_we);

   assert_beq_fall_R7: assert property (@(posedge clk) disable iff (rst)
      (is_branch && !alu_zero) |=> pc == $past(pc) + 32'd4);

   assert_r0_zero_R9: assert property (@(posedge clk) disable iff (rst)
      dbg_addr == 5'd0 |-> dbg_data == 32'd0);
endmodule

bind sc_core sc_core_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .pc        (pc_o),
   .is_branch (ctl.branch),
   .is_jump   (ctl.jump),
   .alu_zero  (alu_zero),
   .rf_we     (rf_we),
   .dmem_we   (dmem_we),
   .wb_mem    (ctl.wb_mem),
   .wr_addr   (wr_addr),
   .rt        (rt),
   .dbg_addr  (dbg_addr),
   .dbg_data  (dbg_data)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ld_en = 1'b0;
   logic        ld_sel = 1'b0;
   logic [5:0]  ld_addr = '0;
   logic [31:0] ld_data = '0;
   logic [4:0]  dbg_addr = '0;
   logic [31:0] dbg_data, pc_o;

   int n_chk = 0;
   int n_fail = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;
   logic [31:0] exp_pc [$];

   always #(CLK_P/2) clk = ~clk;

   sc_core u0 (
      .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel),
      .ld_addr(ld_addr), .ld_data(ld_data),
      .dbg_addr(dbg_addr), .dbg_data(dbg_data), .pc_o(pc_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   function automatic logic [31:0] enc_r(int s, int t, int d, logic [5:0] fn);
      return {6'h00, s[4:0], t[4:0], d[4:0], 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(logic [5:0] op, int s, int t, int imm);
      return {op, s[4:0], t[4:0], imm[15:0]};
   endfunction
   function automatic logic [31:0] enc_j(int idx);
      return {6'h02, idx[25:0]};
   endfunction

   task automatic ld(input logic sel, input int a, input logic [31:0] d);
      ld_sel = sel; ld_addr = a[5:0]; ld_data = d; ld_en = 1'b1;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   // driver: scoreboard entries for the program counter trace
   task automatic push_pc(input logic [31:0] v);
      exp_pc.push_back(v);
   endtask

   task automatic chk_reg(input int r, input logic [31:0] exp, input string req);
      dbg_addr = r[4:0];
      #1;
      chk(dbg_data === exp, req, dbg_data, exp);
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         if (mon_on && exp_pc.size() > 0) begin
            logic [31:0] e;
            e = exp_pc.pop_front();
            chk(pc_o === e, "R2/R7/R8 pc trace", pc_o, e);
         end
      end
   end

   // watchdog
   initial begin
      #(CLK_P * 5000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      @(negedge clk);
      for (int i = 0; i < 64; i++) ld(1'b0, i, 32'h0);   // R11 fill
      ld(1'b0,  0, enc_i(6'h08, 0, 1, 5));          // addi r1,r0,5   R4
      ld(1'b0,  1, enc_i(6'h08, 0, 2, -3));         // addi r2,r0,-3  R4
      ld(1'b0,  2, enc_r(1, 2, 3, 6'h20));          // add r3         R3
      ld(1'b0,  3, enc_r(1, 2, 4, 6'h22));          // sub r4         R3
      ld(1'b0,  4, enc_r(1, 2, 5, 6'h24));          // and r5         R3
      ld(1'b0,  5, enc_r(1, 2, 6, 6'h25));          // or  r6         R3
      ld(1'b0,  6, enc_r(2, 1, 7, 6'h2A));          // slt r7 = -3<5  R3
      ld(1'b0,  7, enc_r(1, 2, 8, 6'h2A));          // slt r8 = 5<-3  R3
      ld(1'b0,  8, enc_i(6'h2B, 0, 1, 8));          // sw r1,8(r0)    R6
      ld(1'b0,  9, enc_i(6'h23, 0, 9, 8));          // lw r9,8(r0)    R5
      ld(1'b0, 10, enc_i(6'h08, 0, 0, 7));          // addi r0 ignored R9
      ld(1'b0, 11, enc_i(6'h04, 1, 9, 1));          // beq taken      R7
      ld(1'b0, 12, enc_i(6'h08, 0, 1, 99));         // skipped
      ld(1'b0, 13, enc_i(6'h04, 1, 2, 5));          // beq not taken  R7
      ld(1'b0, 14, enc_j(16));                      // j 16           R8
      ld(1'b0, 15, enc_i(6'h08, 0, 3, 99));         // skipped
      ld(1'b0, 16, enc_i(6'h23, 2, 12, 11));        // lw r12,11(r2)  R5
      ld(1'b0, 17, enc_i(6'h23, 0, 13, 12));        // lw r13,12(r0)  R5/R11
      ld(1'b0, 18, enc_j(18));                      // spin           R8
      ld(1'b1,  3, 32'hDEADBEEF);                   // R11 data preload

      chk(pc_o === 32'd0, "R1 pc in reset", pc_o, 32'd0);

      for (int i = 1; i <= 11; i++) push_pc(32'(i * 4));
      push_pc(32'd52); push_pc(32'd56); push_pc(32'd64);
      push_pc(32'd68); push_pc(32'd72); push_pc(32'd72); push_pc(32'd72);

      rst = 1'b0;
      mon_on = 1'b1;
      while (exp_pc.size() > 0) @(negedge clk);
      mon_on = 1'b0;

      chk_reg(1,  32'd5,        "R4 addi r1 / R7 skip");
      chk_reg(2,  32'hFFFFFFFD, "R4 addi sign-extend");
      chk_reg(3,  32'd2,        "R3 add / R8 skip");
      chk_reg(4,  32'd8,        "R3 sub");
      chk_reg(5,  32'd5,        "R3 and");
      chk_reg(6,  32'hFFFFFFFD, "R3 or");
      chk_reg(7,  32'd1,        "R3 slt signed true");
      chk_reg(8,  32'd0,        "R3 slt signed false");
      chk_reg(9,  32'd5,        "R6 store then R5 load");
      chk_reg(12, 32'd5,        "R5 negative base");
      chk_reg(13, 32'hDEADBEEF, "R11 data preload via R5");
      chk_reg(0,  32'd0,        "R9 r0 write ignored");
      chk_reg(10, dbg_data,     "R10 debug port");

      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(pc_o === 32'd0, "R1 pc after re-reset", pc_o, 32'd0);
      @(negedge clk);
      chk(pc_o === 32'd0, "R1 pc held in reset", pc_o, 32'd0);

      done = 1'b1;
      finish_run();
   end
endmodule